// File: doc/BRIEF.md
# Deferred Prefetch Abort Tagging Pipeline

This block follows each fetched instruction word through a three-slot pipeline: fetch, decode and execute. Each slot carries two tags, an occupancy (valid) bit and an abort bit. When the memory system flags a fault on an instruction fetch, the block raises no exception at that point. It records the fault as the abort tag of that word, and the tag moves forward with the word.

The prefetch-abort exception is raised only when a tagged word sits in the execute slot and completes its cycle there. A taken branch can discard the word before it gets that far. So can a higher-priority exception such as a data abort or an interrupt. In either case the fault is dropped and no exception is raised.

When the exception is raised, the block also provides the return link. The handler subtracts 4 from this value to re-run the faulting instruction. Instruction decode is not part of this block.

Top module: `ifetch_abort_tag`

## Requirements
- R1: While reset is held and on the first cycle after it, every valid tag, every abort tag and `pabt_exc_o` are 0.
- R2: A fetch (`fetch_i`=1) with `fetch_err_i`=1 loads the fetch slot with valid=1 and abort=1 at the next edge, and raises no exception while the word is outside the execute slot. Bit positions in `stage_valid_o` and `stage_abort_o` are: bit 0 fetch, bit 1 decode, bit 2 execute.
- R3: When no stall, flush, priority exception or abort exception is active, the tags move one slot toward execute at each edge, and the fetch slot takes the current fetch. An aborted fetch therefore reaches execute on the third cycle after its fetch cycle.
- R4: `pabt_exc_o` is 1 for exactly one cycle. On that edge the decode and execute slots are emptied, so a second aborted word already in decode is discarded without raising its own exception.
- R5: While `pabt_exc_o` is 1, `link_o` equals the address of the faulting fetch plus 4.
- R6: When `flush_i` is 1, the decode and execute slots become empty at that edge, and the fetch slot takes the fetch of that same cycle. A discarded aborted word never raises an exception.
- R7: When `stall_i` is 1 and neither `flush_i` nor `prio_exc_i` is 1, all tags hold their values, the fetch inputs are ignored, and no exception is raised even if an aborted word sits in execute.
- R8: When `prio_exc_i` is 1, `pabt_exc_o` stays 0 and the pipeline is flushed as in R6. An aborted word in execute is therefore discarded.
- R9: An abort tag is never 1 in a slot whose valid tag is 0. `fetch_err_i` has no effect when `fetch_i` is 0, and a word fetched without a fault never raises an exception.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| fetch_i | input | 1 | A fetched word is delivered this cycle |
| fetch_addr_i | input | AW | Address of the fetched word |
| fetch_err_i | input | 1 | Memory fault reported on this fetch |
| flush_i | input | 1 | Taken branch: discard the younger slots |
| stall_i | input | 1 | Hold the pipeline |
| prio_exc_i | input | 1 | Data abort or interrupt taken this cycle |
| stage_valid_o | output | 3 | Valid tags: bit 0 fetch, bit 1 decode, bit 2 execute |
| stage_abort_o | output | 3 | Abort tags, same bit order |
| pabt_exc_o | output | 1 | Prefetch-abort exception pulse |
| link_o | output | AW | Execute-slot address plus 4 |

## Verification
The assertions check on every cycle the rules that involve only a single edge: tags step forward (R3), tags hold under a stall (R7), slots empty after a flush or after the exception pulse (R4, R6), the priority exception suppresses the prefetch abort (R8), and an abort tag never stands without its valid tag (R9). Only the bench scenarios show the outcomes that span several cycles. These are the exact cycle on which an aborted fetch traps, the link value of each trap (R5), and faulted words that disappear after a flush, a priority exception or a second fault in decode. A scoreboard records every trap the scenarios should produce and treats any extra trap as a failure.

// File: rtl/pabt_pkg.sv
package pabt_pkg;
  localparam int unsigned NSTG  = 3;
  localparam int unsigned STG_F = 0;
  localparam int unsigned STG_E = NSTG - 1;

  typedef struct packed {
    logic vld;
    logic abt;
  } tag_t;

  localparam tag_t TAG_EMPTY = '{vld: 1'b0, abt: 1'b0};
endpackage

// File: rtl/pabt_stage_reg.sv
module pabt_stage_reg
  import pabt_pkg::*;
#(
  parameter int unsigned AW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          hold_i,
  input  logic          clr_i,
  input  tag_t          tag_i,
  input  logic [AW-1:0] addr_i,
  output tag_t          tag_o,
  output logic [AW-1:0] addr_o
);
  tag_t          tag_q;
  logic [AW-1:0] addr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tag_q  <= TAG_EMPTY;
      addr_q <= '0;
    end else if (clr_i) begin
      tag_q  <= TAG_EMPTY;
    end else if (!hold_i) begin
      tag_q  <= tag_i;
      addr_q <= addr_i;
    end
  end

  assign tag_o  = tag_q;
  assign addr_o = addr_q;
endmodule

// File: rtl/pabt_ctrl.sv
module pabt_ctrl
  import pabt_pkg::*;
(
  input  logic stall_i,
  input  logic flush_i,
  input  logic prio_exc_i,
  input  tag_t exe_tag_i,
  output logic take_o,
  output logic kill_o,
  output logic hold_o
);
  // prefetch abort ranks below branch flush and data abort / interrupt
  assign take_o = exe_tag_i.vld & exe_tag_i.abt & ~stall_i & ~flush_i & ~prio_exc_i;
  assign kill_o = take_o | flush_i | prio_exc_i;
  assign hold_o = stall_i & ~kill_o;
endmodule

// File: rtl/pabt_link.sv
module pabt_link #(
  parameter int unsigned AW  = 32,
  parameter int unsigned OFS = 4
) (
  input  logic [AW-1:0] addr_i,
  output logic [AW-1:0] link_o
);
  localparam logic [AW-1:0] OFS_V = AW'(OFS);
  assign link_o = addr_i + OFS_V;
endmodule

// File: rtl/ifetch_abort_tag.sv
module ifetch_abort_tag
  import pabt_pkg::*;
#(
  parameter int unsigned AW       = 32,
  parameter int unsigned LINK_OFS = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               fetch_i,
  input  logic [AW-1:0]      fetch_addr_i,
  input  logic               fetch_err_i,
  input  logic               flush_i,
  input  logic               stall_i,
  input  logic               prio_exc_i,
  output logic [NSTG-1:0]    stage_valid_o,
  output logic [NSTG-1:0]    stage_abort_o,
  output logic               pabt_exc_o,
  output logic [AW-1:0]      link_o
);
  tag_t          tag_in  [NSTG];
  tag_t          tag_q   [NSTG];
  logic [AW-1:0] addr_in [NSTG];
  logic [AW-1:0] addr_q  [NSTG];
  logic          take, kill, hold;

  pabt_ctrl u_ctrl (
    .stall_i    (stall_i),
    .flush_i    (flush_i),
    .prio_exc_i (prio_exc_i),
    .exe_tag_i  (tag_q[STG_E]),
    .take_o     (take),
    .kill_o     (kill),
    .hold_o     (hold)
  );

  for (genvar i = 0; i < NSTG; i++) begin : g_stg
    if (i == STG_F) begin : g_fetch
      // fetch slot always accepts the redirect fetch, even on a kill
      assign tag_in[i]  = '{vld: fetch_i, abt: fetch_i & fetch_err_i};
      assign addr_in[i] = fetch_addr_i;
      pabt_stage_reg #(.AW(AW)) u_reg (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .hold_i (hold),
        .clr_i  (1'b0),
        .tag_i  (tag_in[i]),
        .addr_i (addr_in[i]),
        .tag_o  (tag_q[i]),
        .addr_o (addr_q[i])
      );
    end else begin : g_mid
      assign tag_in[i]  = tag_q[i-1];
      assign addr_in[i] = addr_q[i-1];
      pabt_stage_reg #(.AW(AW)) u_reg (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .hold_i (hold),
        .clr_i  (kill),
        .tag_i  (tag_in[i]),
        .addr_i (addr_in[i]),
        .tag_o  (tag_q[i]),
        .addr_o (addr_q[i])
      );
    end
    assign stage_valid_o[i] = tag_q[i].vld;
    assign stage_abort_o[i] = tag_q[i].abt;
  end

  pabt_link #(.AW(AW), .OFS(LINK_OFS)) u_link (
    .addr_i (addr_q[STG_E]),
    .link_o (link_o)
  );

  assign pabt_exc_o = take;
endmodule

// File: rtl/pabt_chk.sv
module pabt_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       flush_i,
  input logic       stall_i,
  input logic       prio_exc_i,
  input logic [2:0] stage_valid_o,
  input logic [2:0] stage_abort_o,
  input logic       pabt_exc_o
);
  // R2
  trap_needs_tag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pabt_exc_o |-> (stage_valid_o[2] && stage_abort_o[2]));

  // R3
  advance_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!stall_i && !flush_i && !prio_exc_i && !pabt_exc_o) |=>
      (stage_valid_o[2:1] == $past(stage_valid_o[1:0]) &&
       stage_abort_o[2:1] == $past(stage_abort_o[1:0])));

  // R4
  single_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pabt_exc_o |=> (!pabt_exc_o && stage_valid_o[2:1] == 2'b00));

  // R6
  flush_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> (stage_valid_o[2:1] == 2'b00 && stage_abort_o[2:1] == 2'b00));

  // R7
  stall_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stall_i && !flush_i && !prio_exc_i) |=>
      ($stable(stage_valid_o) && $stable(stage_abort_o)));

  // R7
  stall_no_trap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_i |-> !pabt_exc_o);

  // R8
  prio_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prio_exc_i |-> !pabt_exc_o);

  // R9
  tag_pair_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stage_abort_o & ~stage_valid_o) == 3'b000);
endmodule

bind ifetch_abort_tag pabt_chk u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .flush_i       (flush_i),
  .stall_i       (stall_i),
  .prio_exc_i    (prio_exc_i),
  .stage_valid_o (stage_valid_o),
  .stage_abort_o (stage_abort_o),
  .pabt_exc_o    (pabt_exc_o)
);

// File: tb/ifetch_abort_tag_test.sv
module ifetch_abort_tag_test;
  localparam int AW = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          fetch = 1'b0, err = 1'b0, flush = 1'b0, stall = 1'b0, prio = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [2:0]    vld, abt;
  logic          exc;
  logic [AW-1:0] link;

  int checks = 0;
  int fails  = 0;
  logic [AW-1:0] exp_q[$];
  bit done = 1'b0;

  always #5 clk = ~clk;

  ifetch_abort_tag #(.AW(AW)) uut (
    .clk_i(clk), .rst_ni(rst_n), .fetch_i(fetch), .fetch_addr_i(addr),
    .fetch_err_i(err), .flush_i(flush), .stall_i(stall), .prio_exc_i(prio),
    .stage_valid_o(vld), .stage_abort_o(abt), .pabt_exc_o(exc), .link_o(link)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // monitor: every trap must match the next expected link (R5); stray traps fail
  always @(negedge clk) begin
    if (rst_n && exc) begin
      if (exp_q.size() == 0) check("R4/R6/R8/R9 unexpected trap", {31'd0, exc}, 32'd0);
      else check("R5 link", link, exp_q.pop_front());
    end
  end

  // apply inputs for one cycle, sampled at the negedge, latched at next posedge
  task automatic step(input logic f, input logic e, input logic [AW-1:0] a,
                      input logic fl, input logic st, input logic hp);
    fetch = f; err = e; addr = a; flush = fl; stall = st; prio = hp;
    @(negedge clk);
  endtask

  task automatic advance();
    @(posedge clk); #1;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin step(0, 0, '0, 0, 0, 0); advance(); end
  endtask

  initial begin
    #1;
    @(negedge clk);
    check("R1 valid in reset", {29'd0, vld}, 0);
    check("R1 abort in reset", {29'd0, abt}, 0);
    check("R1 trap in reset", {31'd0, exc}, 0);
    @(posedge clk); #1 rst_n = 1'b1;
    @(negedge clk);
    check("R1 valid after reset", {29'd0, vld}, 0);
    advance();

    // scenario A: aborted fetch traps at execute
    exp_q.push_back(32'h104);
    step(1, 1, 32'h100, 0, 0, 0); check("R2 no early trap", {31'd0, exc}, 0); advance();
    step(1, 0, 32'h104, 0, 0, 0);
    check("R2 fetch slot valid", {29'd0, vld}, 3'b001);
    check("R2 fetch slot abort", {29'd0, abt}, 3'b001);
    check("R2 no trap in fetch", {31'd0, exc}, 0); advance();
    step(1, 0, 32'h108, 0, 0, 0);
    check("R3 decode tags v", {29'd0, vld}, 3'b011);
    check("R3 decode tags a", {29'd0, abt}, 3'b010); advance();
    step(1, 0, 32'h10C, 0, 0, 0);
    check("R3 execute tags v", {29'd0, vld}, 3'b111);
    check("R3 execute tags a", {29'd0, abt}, 3'b100);
    check("R3 trap at execute", {31'd0, exc}, 1); advance();
    step(0, 0, '0, 0, 0, 0);
    check("R4 pulse ends", {31'd0, exc}, 0);
    check("R4 slots flushed", {29'd0, vld}, 3'b001); advance();
    idle(4);

    // scenario B: flush discards aborted word
    step(1, 1, 32'h200, 0, 0, 0); advance();
    step(1, 0, 32'h204, 0, 0, 0); advance();
    step(1, 0, 32'h300, 1, 0, 0);
    check("R6 before flush a", {29'd0, abt}, 3'b010); advance();
    step(0, 0, '0, 0, 0, 0);
    check("R6 after flush v", {29'd0, vld}, 3'b001);
    check("R6 after flush a", {29'd0, abt}, 3'b000); advance();
    idle(4);

    // scenario C: stall holds tags and delays the trap
    exp_q.push_back(32'h404);
    step(1, 1, 32'h400, 0, 0, 0); advance();
    step(1, 1, 32'h500, 0, 1, 0); advance();
    step(1, 0, 32'h504, 0, 1, 0);
    check("R7 hold v", {29'd0, vld}, 3'b001);
    check("R7 hold a", {29'd0, abt}, 3'b001); advance();
    step(0, 0, '0, 0, 0, 0); advance();
    step(0, 0, '0, 0, 0, 0); advance();
    step(0, 0, '0, 0, 1, 0);
    check("R7 execute abort held", {29'd0, abt}, 3'b100);
    check("R7 no trap while stalled", {31'd0, exc}, 0); advance();
    step(0, 0, '0, 0, 0, 0);
    check("R7 trap after stall", {31'd0, exc}, 1); advance();
    idle(3);

    // scenario D: priority exception outranks the prefetch abort
    step(1, 1, 32'h600, 0, 0, 0); advance();
    idle(2);
    step(0, 0, '0, 0, 0, 1);
    check("R8 abort at execute", {29'd0, abt}, 3'b100);
    check("R8 trap suppressed", {31'd0, exc}, 0); advance();
    step(0, 0, '0, 0, 0, 0);
    check("R8 pipeline flushed", {29'd0, vld}, 3'b000); advance();
    idle(4);

    // scenario E: fault without fetch ignored; clean fetch never traps
    step(1, 0, 32'h700, 0, 0, 0); advance();
    step(0, 1, 32'h704, 0, 0, 0);
    check("R9 clean fetch v", {29'd0, vld}, 3'b001);
    check("R9 clean fetch a", {29'd0, abt}, 3'b000); advance();
    step(0, 0, '0, 0, 0, 0);
    check("R9 fault w/o fetch v", {29'd0, vld}, 3'b010);
    check("R9 fault w/o fetch a", {29'd0, abt}, 3'b000); advance();
    idle(4);

    // scenario F: second aborted word in decode dies with the first trap
    exp_q.push_back(32'h804);
    step(1, 1, 32'h800, 0, 0, 0); advance();
    step(1, 1, 32'h804, 0, 0, 0); advance();
    idle(1);
    step(0, 0, '0, 0, 0, 0);
    check("R4 first trap", {31'd0, exc}, 1); advance();
    idle(5);

    check("R5 all expected traps seen", exp_q.size(), 0);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule